// File: doc/BRIEF.md
# SD Card Clock Output Controller

This block drives the clock pin of an SD-style card host from a master clock. Software programs two 32-bit registers over a simple single-cycle write port with a combinational read port. One register holds a two-bit power state. The other holds a clock enable, an edge-phase select, a bus-width code and a write-one-to-clear bit for a sticky error flag. The card clock toggles only when the power state is "on" and the enable bit is set. It runs at half the master clock rate. Its transitions line up either with rising or with falling master-clock edges.

Writes to the power register must be spaced by a minimum number of bus clocks. A write that comes too early is dropped, and a sticky spacing-error flag is raised. The block also decodes the bus-width code into one enable bit per data lane, for use by the data path.

Top module: `cardclk_top`

## Requirements
- R1: After reset both registers read zero, the card clock is low, only lane 0 is enabled and the spacing-error flag is low.
- R2: With power state 2'b11 in bits [1:0] of the power register (offset 0x0) and the enable bit (bit 0 of the clock register, offset 0x4) set, the card clock changes level on every master clock edge of the selected kind, giving one full period per two master clocks. With power state 2'b00 it stays low.
- R3: Power states 2'b01 and 2'b10 are stored and read back, but they never let the card clock toggle. The powerOn output is high only for state 2'b11.
- R4: With the enable bit clear, the card clock stays low in every power state.
- R5: A power-register write that lands fewer than 7 bus clocks after the last accepted one leaves the register unchanged and sets spacingErr. A write 7 or more clocks later is accepted. The first write after reset is always accepted.
- R6: spacingErr stays set until a clock-register write with bit 4 set clears it. Bit 4 always reads 0.
- R7: With the phase bit (bit 1 of the clock register) at 0, every card-clock transition follows a rising master-clock edge. With it at 1, every transition follows a falling edge.
- R8: Bus-width code bits [3:2] of the clock register drive laneEn: 2'b00 gives 8'h01, 2'b01 gives 8'h0F, 2'b10 gives 8'hFF, and the unused 2'b11 gives 8'h01.
- R9: All bits above the defined fields read zero, in both registers, and any other address reads zero.
- R10: Gating is glitch-free. A high phase of the card clock always lasts exactly one master-clock period, and a change of enable or phase takes effect only while the card clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master and bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 4 | Register byte address (0x0 power, 0x4 clock) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| cardClk | output | 1 | Gated card clock |
| laneEn | output | 8 | Active data-lane enables |
| powerOn | output | 1 | High while the power state is on |
| spacingErr | output | 1 | Sticky too-close power-write flag |

## Verification
The assertions assume that regWr is a single-cycle strobe carrying one address at a time. That way a power write and a clearing clock-register write can never land in the same cycle. They also assume that reset is released away from a master-clock edge. The bench drives every input on the falling half-cycle, issues writes one at a time through a single task, and releases reset between edges. The random phase varies the gaps between power writes across the 7-cycle limit and scatters clear requests. Each measurement window starts only after a few idle cycles, so that the pulse gating and phase handover have settled.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

  // register byte offsets
  localparam int unsigned PWR_OFS = 0;
  localparam int unsigned CLK_OFS = 4;

  // clock-register field positions
  localparam int unsigned CC_EN_BIT   = 0;
  localparam int unsigned CC_FALL_BIT = 1;
  localparam int unsigned CC_WID_LSB  = 2;
  localparam int unsigned CC_CLR_BIT  = 4;

  typedef enum logic [1:0] {
    PWR_OFF   = 2'b00,
    PWR_RSV_A = 2'b01,
    PWR_RSV_B = 2'b10,
    PWR_ON    = 2'b11
  } pwrStateE;

  typedef enum logic [1:0] {
    BW_1   = 2'b00,
    BW_4   = 2'b01,
    BW_8   = 2'b10,
    BW_RSV = 2'b11
  } busWidthE;

  // strobes from the register side to the clock datapath
  typedef struct packed {
    logic     runEn;
    logic     fallSel;
    busWidthE busWidth;
  } clkCtrlT;

endpackage

// File: rtl/cardclk_regs.sv
module cardclk_regs
  import cardclk_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int MIN_GAP = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output clkCtrlT           ctrl,
  output logic              powerOn,
  output logic              spacingErr
);

  localparam int GAP_W = $clog2(MIN_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(MIN_GAP - 1);
  localparam logic [ADDR_W-1:0] PWR_ADDR = ADDR_W'(PWR_OFS);
  localparam logic [ADDR_W-1:0] CLK_ADDR = ADDR_W'(CLK_OFS);

  pwrStateE          pwrQ;
  logic              clkEnQ;
  logic              fallQ;
  busWidthE          widthQ;
  logic              errQ;
  logic [GAP_W-1:0]  gapCnt;

  logic pwrHit, clkHit, pwrOk, pwrTake, pwrReject, clrReq;
  logic unusedWdata;

  assign pwrHit    = regWr && (regAddr == PWR_ADDR);
  assign clkHit    = regWr && (regAddr == CLK_ADDR);
  assign pwrOk     = (gapCnt >= GAP_LIM);
  assign pwrTake   = pwrHit && pwrOk;
  assign pwrReject = pwrHit && !pwrOk;
  assign clrReq    = clkHit && regWdata[CC_CLR_BIT];
  assign unusedWdata = ^regWdata[DATA_W-1:CC_CLR_BIT+1];

  // bus clocks elapsed since the last accepted power write, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= GAP_LIM;
    end else if (pwrTake) begin
      gapCnt <= '0;
    end else if (gapCnt < GAP_LIM) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrQ <= PWR_OFF;
    end else if (pwrTake) begin
      pwrQ <= pwrStateE'(regWdata[1:0]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkEnQ <= 1'b0;
      fallQ  <= 1'b0;
      widthQ <= BW_1;
    end else if (clkHit) begin
      clkEnQ <= regWdata[CC_EN_BIT];
      fallQ  <= regWdata[CC_FALL_BIT];
      widthQ <= busWidthE'(regWdata[CC_WID_LSB +: 2]);
    end
  end

  // sticky spacing flag; setting wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ <= 1'b0;
    end else if (pwrReject) begin
      errQ <= 1'b1;
    end else if (clrReq) begin
      errQ <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == PWR_ADDR) begin
      regRdata[1:0] = pwrQ;
    end else if (regAddr == CLK_ADDR) begin
      regRdata[CC_EN_BIT]         = clkEnQ;
      regRdata[CC_FALL_BIT]       = fallQ;
      regRdata[CC_WID_LSB +: 2]   = widthQ;
    end
  end

  assign powerOn        = (pwrQ == PWR_ON);
  assign spacingErr     = errQ;
  assign ctrl.runEn     = (pwrQ == PWR_ON) && clkEnQ;
  assign ctrl.fallSel   = fallQ;
  assign ctrl.busWidth  = widthQ;

endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
  import cardclk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  clkCtrlT ctrl,
  output logic    cardClk,
  output logic    phaseSel
);

  logic divRise, divFall, phaseQ;
  logic riseGo, fallGo;

  // a new high phase starts only when its edge kind is both active and requested
  assign riseGo = ctrl.runEn && !phaseQ && !ctrl.fallSel;
  assign fallGo = ctrl.runEn &&  phaseQ &&  ctrl.fallSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divRise <= 1'b0;
    end else if (divRise) begin
      divRise <= 1'b0;
    end else begin
      divRise <= riseGo;
    end
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      divFall <= 1'b0;
    end else if (divFall) begin
      divFall <= 1'b0;
    end else begin
      divFall <= fallGo;
    end
  end

  // phase hand-over only while both dividers rest low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= 1'b0;
    end else if (!divRise && !divFall) begin
      phaseQ <= ctrl.fallSel;
    end
  end

  assign cardClk  = phaseQ ? divFall : divRise;
  assign phaseSel = phaseQ;

endmodule

// File: rtl/cardclk_lanes.sv
module cardclk_lanes
  import cardclk_pkg::*;
#(
  parameter int LANES = 8
) (
  input  busWidthE         busWidth,
  output logic [LANES-1:0] laneEn
);

  localparam int NARROW = 4;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i == 0) begin : g_base
      assign laneEn[i] = 1'b1;
    end else if (i < NARROW) begin : g_mid
      assign laneEn[i] = (busWidth == BW_4) || (busWidth == BW_8);
    end else begin : g_wide
      assign laneEn[i] = (busWidth == BW_8);
    end
  end

endmodule

// File: rtl/cardclk_top.sv
module cardclk_top
  import cardclk_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int MIN_GAP = 7,
  parameter int LANES   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              cardClk,
  output logic [LANES-1:0]  laneEn,
  output logic              powerOn,
  output logic              spacingErr
);

  clkCtrlT ctrl;
  logic    phaseSel;

  cardclk_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MIN_GAP(MIN_GAP)
  ) regs_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .ctrl      (ctrl),
    .powerOn   (powerOn),
    .spacingErr(spacingErr)
  );

  cardclk_gen gen_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .cardClk (cardClk),
    .phaseSel(phaseSel)
  );

  cardclk_lanes #(
    .LANES(LANES)
  ) lanes_i (
    .busWidth(ctrl.busWidth),
    .laneEn  (laneEn)
  );

endmodule

// File: rtl/cardclk_chk.sv
module cardclk_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int LANES  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              cardClk,
  input logic [LANES-1:0]  laneEn,
  input logic              powerOn,
  input logic              spacingErr,
  input logic              phaseSel
);

  logic pwrWr, clrWr;
  assign pwrWr = regWr && (regAddr == ADDR_W'(0));
  assign clrWr = regWr && (regAddr == ADDR_W'(4)) && regWdata[4];

  // R2: two cycles without power-on leave the card clock low
  a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!powerOn && $past(!powerOn)) |-> !cardClk);

  // R5: two power writes in adjacent cycles always raise the flag
  a_r5_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    (pwrWr && $past(pwrWr)) |=> spacingErr);

  // R6: the flag only drops on an explicit clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (spacingErr && !clrWr) |=> spacingErr);

  // R8: lane 0 always on, and only 1, 4 or all lanes
  a_r8_lane_set: assert property (@(posedge clk) disable iff (!rstN)
    laneEn[0] && ($countones(laneEn) == 1 || $countones(laneEn) == 4
                  || $countones(laneEn) == LANES));

  // R9: nothing above the defined fields ever reads back
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[DATA_W-1:5] == '0);

  // R10: in rising-edge phase a high level lasts one master period
  a_r10_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    (cardClk && !phaseSel) |=> !cardClk);

endmodule

bind cardclk_top cardclk_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .LANES (LANES)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regWr     (regWr),
  .regAddr   (regAddr),
  .regWdata  (regWdata),
  .regRdata  (regRdata),
  .cardClk   (cardClk),
  .laneEn    (laneEn),
  .powerOn   (powerOn),
  .spacingErr(spacingErr),
  .phaseSel  (phaseSel)
);

// File: tb/cardclk_top_tb_top.sv
module cardclk_top_tb_top;

  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;
  localparam int MIN_GAP = 7;
  localparam int LANES   = 8;
  localparam int WIN     = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWr = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic              cardClk;
  logic [LANES-1:0]  laneEn;
  logic              powerOn;
  logic              spacingErr;

  always #2 clk = ~clk;

  cardclk_top #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_GAP(MIN_GAP), .LANES(LANES)
  ) dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .cardClk(cardClk),
    .laneEn(laneEn), .powerOn(powerOn), .spacingErr(spacingErr)
  );

  int nChk = 0;
  int nFail = 0;
  int tick = 0;
  bit done = 0;
  always @(posedge clk) tick <= tick + 1;

  // bench model
  logic [1:0] pwrExp = 2'b00;
  logic [3:0] ccExp  = 4'h0;   // {width, fall, en}
  logic       errExp = 1'b0;
  int         lastAcc = -1000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] laneFn(input logic [1:0] w);
    case (w)
      2'b01:   return 8'h0F;
      2'b10:   return 8'hFF;
      default: return 8'h01;
    endcase
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [3:0] addr, input logic [31:0] data);
    @(negedge clk);
    regWr = 1'b1; regAddr = addr; regWdata = data;
    @(posedge clk); #1;
    regWr = 1'b0;
    if (addr == 4'h4) begin
      ccExp = data[3:0];
      if (data[4]) errExp = 1'b0;
    end else if (addr == 4'h0) begin
      if (tick - lastAcc >= MIN_GAP) begin
        pwrExp = data[1:0];
        lastAcc = tick;
      end else begin
        errExp = 1'b1;
      end
    end
  endtask

  task automatic readReg(input logic [3:0] addr, output logic [31:0] data);
    @(negedge clk);
    regAddr = addr;
    #1 data = regRdata;
  endtask

  task automatic measure(input int n, output int rT, output int fT);
    logic prev;
    rT = 0; fT = 0;
    @(negedge clk); #1 prev = cardClk;
    repeat (n) begin
      @(posedge clk); #1;
      if (cardClk !== prev) rT++;
      prev = cardClk;
      @(negedge clk); #1;
      if (cardClk !== prev) fT++;
      prev = cardClk;
    end
  endtask

  // full comparison against the model: R3 R5 R6 R8 R9 R2 R4 R7
  task automatic checkAll(input string tag);
    logic [31:0] rd;
    int rT, fT;
    bit run;
    idle(3);
    readReg(4'h0, rd);
    check({tag, " R3/R5 power readback"}, rd, {30'b0, pwrExp});
    readReg(4'h4, rd);
    check({tag, " R9/R6 clock readback"}, rd, {28'b0, ccExp});
    check({tag, " R8 lanes"}, {24'b0, laneEn}, {24'b0, laneFn(ccExp[3:2])});
    check({tag, " R6 spacingErr"}, {31'b0, spacingErr}, {31'b0, errExp});
    check({tag, " R3 powerOn"}, {31'b0, powerOn}, {31'b0, pwrExp == 2'b11});
    run = (pwrExp == 2'b11) && ccExp[0];
    measure(WIN, rT, fT);
    check({tag, " R2/R4/R7 rise toggles"}, rT, (run && !ccExp[1]) ? WIN : 0);
    check({tag, " R2/R4/R7 fall toggles"}, fT, (run &&  ccExp[1]) ? WIN : 0);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    int seedInit;
    seedInit = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    readReg(4'h0, rd);  check("R1 power reg reset", rd, 32'h0);
    readReg(4'h4, rd);  check("R1 clock reg reset", rd, 32'h0);
    check("R1 lanes reset", {24'b0, laneEn}, 32'h01);
    check("R1 cardClk low", {31'b0, cardClk}, 32'h0);
    check("R1 spacingErr low", {31'b0, spacingErr}, 32'h0);
    checkAll("R1 idle");

    // R2 R7: run in rising phase, then falling phase
    writeReg(4'h4, 32'h0000_0001);
    writeReg(4'h0, 32'h0000_0003);
    checkAll("R2 rise run");
    writeReg(4'h4, 32'hFFFF_FFE3);   // R9: junk above fields
    checkAll("R7 fall run");
    // R4: enable off
    writeReg(4'h4, 32'h0000_0002);
    checkAll("R4 enable off");
    // R3: reserved power states
    writeReg(4'h4, 32'h0000_0001);
    writeReg(4'h0, 32'hFFFF_FFFD);   // state 01
    checkAll("R3 state 01");
    writeReg(4'h0, 32'h0000_0002);
    checkAll("R3 state 10");

    // R5: gap of 6 rejected, gap of 7 accepted
    writeReg(4'h0, 32'h0000_0003);
    idle(5);
    writeReg(4'h0, 32'h0000_0000);
    checkAll("R5 gap 6 reject");
    check("R5 flag after reject", {31'b0, spacingErr}, 32'h1);
    idle(4);
    check("R6 flag sticky", {31'b0, spacingErr}, 32'h1);
    writeReg(4'h4, 32'h0000_0011);   // clear, keep enable
    checkAll("R6 cleared");
    writeReg(4'h0, 32'h0000_0003);
    idle(5);
    writeReg(4'h0, 32'h0000_0000);
    idle(0);
    writeReg(4'h4, 32'h0000_0011);
    writeReg(4'h0, 32'h0000_0003);
    idle(6);
    writeReg(4'h0, 32'h0000_0000);
    checkAll("R5 gap 7 accept");

    // R8: every width code, R9: unmapped address
    writeReg(4'h4, 32'h0000_0005);  checkAll("R8 width 01");
    writeReg(4'h4, 32'h0000_0009);  checkAll("R8 width 10");
    writeReg(4'h4, 32'h0000_000D);  checkAll("R8 width 11");
    readReg(4'h8, rd);  check("R9 unmapped read", rd, 32'h0);

    // random mix, R10 pulse shape covered by the toggle counts
    for (int it = 0; it < 40; it++) begin
      logic [31:0] cw;
      cw = ($urandom & 32'hFFFF_FFE0) | ($urandom & 32'h0000_000F);
      if ($urandom_range(0, 3) == 0) cw[4] = 1'b1;
      writeReg(4'h4, cw);
      idle($urandom_range(0, 8));
      writeReg(4'h0, $urandom);
      if ($urandom_range(0, 2) == 0) writeReg(4'h0, $urandom);
      checkAll("R10 random");
    end

    finishRun();
  end

endmodule